// File: doc/BRIEF.md
# DMA Request Channel Synchronizer

One channel of a DMA request router. A 7-bit selector chooses one peripheral request line from a wide request bus and sends it to the DMA controller. When gating is off, the chosen line goes straight through. When gating is on, the request is held back until an edge arrives on a chosen synchronization input. The synchronization input is one of 32 lines, chosen by a 5-bit selector, and the edge can be rising, falling or both. The edge opens a window, and the window lets a programmed number of requests through. A request counts as consumed on the cycle in which the DMA acknowledge is seen while the forwarded request is high.

The channel can also produce a single-cycle completion pulse each time a full batch of requests has been consumed. It raises a sticky overrun flag when an edge arrives while the previous window still has requests outstanding. An interrupt enable routes that flag to an interrupt output. All settings sit in one 32-bit configuration word. The word takes aligned byte, halfword and word writes and can be read back at any time.

Top module: `dma_req_sync_chan`

## Requirements
- R1: After reset the configuration word reads 0x00000000, and the request, completion pulse and interrupt outputs are low.
- R2: With gating off (bit 15 = 0), `dma_req_out` equals `req_bus[req_sel]` in the same cycle, where req_sel is bits [6:0].
- R3: Bits [12:8] choose the synchronization line. Bits [14:13] choose the edge: 00 never triggers, 01 triggers on a rising edge, 10 on a falling edge, 11 on either. Edges on lines that are not selected have no effect. Each line passes through a two-flop synchronizer before edge detection.
- R4: With gating on, `dma_req_out` stays low while no window is open. An edge opens a window that forwards exactly N+1 requests, where N is bits [20:16] and can be from 0 to 31. The window then closes.
- R5: With the completion enable (bit 21) set, `evt_pulse` is high for one cycle, in the cycle after the acknowledge that completes each run of N+1 consumed requests.
- R6: A write to bits [20:16] takes effect only if bits 15 and 21 are both 0 before that write. Otherwise the field keeps its value.
- R7: Byte enables 0001, 0010, 0100 and 1000, halfword enables 0011 and 1100, and word enable 1111 update only their own lanes. Any other enable pattern changes nothing. Unused bit positions read as zero.
- R8: An edge that arrives while the current window still has requests outstanding sets bit 31. The edge does not reload the window. Bit 31 stays set until a write with lane 3 enabled and data bit 31 = 1 clears it.
- R9: `ovr_irq` is high exactly when bit 31 and the interrupt enable (bit 22) are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_bus | input | NUM_REQ | Peripheral request lines |
| sync_bus | input | NUM_SYNC | Asynchronous synchronization lines |
| dma_ack | input | 1 | DMA acknowledge of the forwarded request |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wstrb | input | 4 | Byte-lane enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current configuration word |
| dma_req_out | output | 1 | Request to the DMA controller |
| evt_pulse | output | 1 | Completion pulse |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
The bench uses the default parameters: 128 request lines, 32 synchronization lines and two synchronizer stages. With these values the top selector codes can be reached, namely request line 127 and synchronization line 31. The largest count, 32 requests in one window together with the completion pulse on the 32nd, is also reached. The counter's range edge and the selector decode edge are therefore exercised directly, not through a reduced build.

// File: rtl/dma_sync_pkg.sv
// Shared constants, field positions and types of the request channel
// synchronizer. Assumes a 32-bit configuration word with four byte lanes.
package dma_sync_pkg;

    localparam int REQ_SEL_W  = 7;
    localparam int SYNC_SEL_W = 5;
    localparam int CNT_W      = 5;
    localparam int REM_W      = CNT_W + 1;

    // Field positions inside the configuration word
    localparam int REQ_LSB  = 0;
    localparam int SYNC_LSB = 8;
    localparam int POL_LSB  = 13;
    localparam int SEN_BIT  = 15;
    localparam int CNT_LSB  = 16;
    localparam int EVT_BIT  = 21;
    localparam int OIE_BIT  = 22;
    localparam int OVR_BIT  = 31;

    typedef enum logic [1:0] {
        POL_NONE = 2'b00,
        POL_RISE = 2'b01,
        POL_FALL = 2'b10,
        POL_BOTH = 2'b11
    } edge_pol_e;

    typedef struct packed {
        logic [REQ_SEL_W-1:0]  req_sel;
        logic [SYNC_SEL_W-1:0] sync_sel;
        edge_pol_e             pol;
        logic                  sync_en;
        logic [CNT_W-1:0]      cnt_m1;
        logic                  evt_en;
        logic                  ovr_ie;
    } chan_cfg_t;

    // True for the aligned byte, halfword and word enable patterns
    function automatic logic strobe_ok(input logic [3:0] s);
        case (s)
            4'b0001, 4'b0010, 4'b0100, 4'b1000,
            4'b0011, 4'b1100, 4'b1111: strobe_ok = 1'b1;
            default:                   strobe_ok = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/chan_cfg_regs.sv
// Configuration word of one channel. It takes aligned byte, halfword and
// word writes and ignores any other enable pattern. The count field is
// locked while gating or completion events are enabled. It also holds the
// sticky overrun flag. Assumes ovr_set is a single-cycle pulse.
module chan_cfg_regs
    import dma_sync_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wstrb,
    input  logic [31:0]      wdata,
    input  logic             ovr_set,
    output chan_cfg_t        cfg,
    output logic             ovr_flag,
    output logic [31:0]      rdata
);

    logic [3:0] lane_we;
    logic       cnt_open;

    // Decode which lanes a legal write touches
    always_comb begin
        for (int i = 0; i < 4; i++) begin
            lane_we[i] = wr_en && strobe_ok(wstrb) && wstrb[i];
        end
    end

    assign cnt_open = !cfg.sync_en && !cfg.evt_en;

    // Update configuration fields lane by lane
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (lane_we[0]) begin
                cfg.req_sel <= wdata[REQ_LSB +: REQ_SEL_W];
            end
            if (lane_we[1]) begin
                cfg.sync_sel <= wdata[SYNC_LSB +: SYNC_SEL_W];
                cfg.pol      <= edge_pol_e'(wdata[POL_LSB +: 2]);
                cfg.sync_en  <= wdata[SEN_BIT];
            end
            if (lane_we[2]) begin
                if (cnt_open) begin
                    cfg.cnt_m1 <= wdata[CNT_LSB +: CNT_W];
                end
                cfg.evt_en <= wdata[EVT_BIT];
                cfg.ovr_ie <= wdata[OIE_BIT];
            end
        end
    end

    // Sticky overrun flag, set wins over a clearing write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
        end else if (ovr_set) begin
            ovr_flag <= 1'b1;
        end else if (lane_we[3] && wdata[OVR_BIT]) begin
            ovr_flag <= 1'b0;
        end
    end

    // Assemble the read view, unused positions stay zero
    always_comb begin
        rdata                           = '0;
        rdata[REQ_LSB +: REQ_SEL_W]     = cfg.req_sel;
        rdata[SYNC_LSB +: SYNC_SEL_W]   = cfg.sync_sel;
        rdata[POL_LSB +: 2]             = cfg.pol;
        rdata[SEN_BIT]                  = cfg.sync_en;
        rdata[CNT_LSB +: CNT_W]         = cfg.cnt_m1;
        rdata[EVT_BIT]                  = cfg.evt_en;
        rdata[OIE_BIT]                  = cfg.ovr_ie;
        rdata[OVR_BIT]                  = ovr_flag;
    end

endmodule

// File: rtl/sync_edge_sel.sv
// Brings every synchronization line into the clock domain through a flop
// chain, picks one line and flags the programmed edge on it. Assumes
// SYNC_STAGES >= 2. A selector change may show as one edge.
module sync_edge_sel
    import dma_sync_pkg::*;
#(
    parameter int NUM_SYNC    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SYNC-1:0]   sync_in,
    input  logic [SYNC_SEL_W-1:0] sel,
    input  edge_pol_e             pol,
    output logic                  sync_evt
);

    logic [NUM_SYNC-1:0] chain [SYNC_STAGES];
    logic                cur;
    logic                prev;

    // Flop chain for metastability settling on all lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) begin
                chain[s] <= '0;
            end
        end else begin
            chain[0] <= sync_in;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    // Pick the selected settled line
    always_comb begin
        cur = 1'b0;
        for (int i = 0; i < NUM_SYNC; i++) begin
            if (sel == SYNC_SEL_W'(i)) begin
                cur = chain[SYNC_STAGES-1][i];
            end
        end
    end

    // Remember the selected line for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
        end else begin
            prev <= cur;
        end
    end

    // Qualify the edge by the programmed polarity
    always_comb begin
        unique case (pol)
            POL_RISE: sync_evt = cur && !prev;
            POL_FALL: sync_evt = !cur && prev;
            POL_BOTH: sync_evt = cur ^ prev;
            default:  sync_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/req_gate_ctr.sv
// Selects the peripheral request and gates it by a window counter that a
// synchronization edge loads. Counts consumed requests for the completion
// pulse and reports overrun. Assumes a request is consumed when dma_ack is
// high while the forwarded request is high.
module req_gate_ctr
    import dma_sync_pkg::*;
#(
    parameter int NUM_REQ = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_REQ-1:0]   req_in,
    input  logic [REQ_SEL_W-1:0] req_sel,
    input  logic                 sync_en,
    input  logic                 evt_en,
    input  logic [CNT_W-1:0]     cnt_m1,
    input  logic                 sync_evt,
    input  logic                 dma_ack,
    output logic                 req_out,
    output logic                 evt_pulse,
    output logic                 ovr_set,
    output logic [REM_W-1:0]     remain
);

    logic             sel_req;
    logic             window;
    logic             consume;
    logic [CNT_W-1:0] done_cnt;

    // Request line multiplexer, codes past NUM_REQ give zero
    always_comb begin
        sel_req = 1'b0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (req_sel == REQ_SEL_W'(i)) begin
                sel_req = req_in[i];
            end
        end
    end

    assign window  = (remain != '0);
    assign req_out = sel_req && (!sync_en || window);
    assign consume = req_out && dma_ack;
    assign ovr_set = sync_en && sync_evt && window;

    // Window counter: load on an edge when idle, count down on consumption
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_en) begin
            remain <= '0;
        end else if (window) begin
            if (consume) begin
                remain <= remain - REM_W'(1);
            end
        end else if (sync_evt) begin
            remain <= {1'b0, cnt_m1} + REM_W'(1);
        end
    end

    // Consumed-request counter for completion events
    always_ff @(posedge clk) begin
        if (!rst_n || !evt_en) begin
            done_cnt <= '0;
        end else if (consume) begin
            done_cnt <= (done_cnt == cnt_m1) ? '0 : done_cnt + CNT_W'(1);
        end
    end

    // Single-cycle completion pulse after the finishing acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_pulse <= 1'b0;
        end else begin
            evt_pulse <= evt_en && consume && (done_cnt == cnt_m1);
        end
    end

endmodule

// File: rtl/dma_req_sync_chan.sv
// Top of one DMA request channel synchronizer: configuration word, sync
// edge detection and request gating. Assumes dma_ack is synchronous to clk.
module dma_req_sync_chan
    import dma_sync_pkg::*;
#(
    parameter int NUM_REQ     = 128,
    parameter int NUM_SYNC    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REQ-1:0]  req_bus,
    input  logic [NUM_SYNC-1:0] sync_bus,
    input  logic                dma_ack,
    input  logic                cfg_wr_en,
    input  logic [3:0]          cfg_wstrb,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    output logic                dma_req_out,
    output logic                evt_pulse,
    output logic                ovr_irq
);

    chan_cfg_t        cfg;
    logic             ovr_flag;
    logic             ovr_set;
    logic             sync_evt;
    logic [REM_W-1:0] remain;

    chan_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wstrb    (cfg_wstrb),
        .wdata    (cfg_wdata),
        .ovr_set  (ovr_set),
        .cfg      (cfg),
        .ovr_flag (ovr_flag),
        .rdata    (cfg_rdata)
    );

    sync_edge_sel #(
        .NUM_SYNC    (NUM_SYNC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_bus),
        .sel      (cfg.sync_sel),
        .pol      (cfg.pol),
        .sync_evt (sync_evt)
    );

    req_gate_ctr #(
        .NUM_REQ (NUM_REQ)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (req_bus),
        .req_sel   (cfg.req_sel),
        .sync_en   (cfg.sync_en),
        .evt_en    (cfg.evt_en),
        .cnt_m1    (cfg.cnt_m1),
        .sync_evt  (sync_evt),
        .dma_ack   (dma_ack),
        .req_out   (dma_req_out),
        .evt_pulse (evt_pulse),
        .ovr_set   (ovr_set),
        .remain    (remain)
    );

    // Overrun interrupt gated by its enable
    assign ovr_irq = ovr_flag && cfg.ovr_ie;

endmodule

// File: rtl/dma_req_sync_chan_chk.sv
// Property checker for the channel synchronizer, bound to the top module.
// Assumes the configuration layout from dma_sync_pkg.
module dma_req_sync_chan_chk
    import dma_sync_pkg::*;
#(
    parameter int NUM_REQ = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req_bus,
    input logic               dma_ack,
    input logic               cfg_wr_en,
    input logic [31:0]        cfg_rdata,
    input logic               dma_req_out,
    input logic               evt_pulse,
    input logic               ovr_irq,
    input logic [REM_W-1:0]   remain
);

    // R2: plain pass-through when gating is off
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata[SEN_BIT] && (int'(cfg_rdata[6:0]) < NUM_REQ))
            |-> (dma_req_out == req_bus[cfg_rdata[6:0]]));

    // R4: no request leaves while gating is on and the window is closed
    p_gate_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[SEN_BIT] && (remain == '0)) |-> !dma_req_out);

    // R5: a completion pulse always follows a consumed request
    p_evt_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> $past(dma_ack && dma_req_out));

    // R6: count field frozen while either enable is set
    p_cnt_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[SEN_BIT] || cfg_rdata[EVT_BIT]) |=> $stable(cfg_rdata[20:16]));

    // R8: overrun flag only drops after a write
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[OVR_BIT] && !cfg_wr_en) |=> cfg_rdata[OVR_BIT]);

    // R9: interrupt implies flag and enable
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_irq |-> (cfg_rdata[OVR_BIT] && cfg_rdata[OIE_BIT]));

endmodule

bind dma_req_sync_chan dma_req_sync_chan_chk #(
    .NUM_REQ (NUM_REQ)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_bus     (req_bus),
    .dma_ack     (dma_ack),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_rdata   (cfg_rdata),
    .dma_req_out (dma_req_out),
    .evt_pulse   (evt_pulse),
    .ovr_irq     (ovr_irq),
    .remain      (remain)
);

// File: tb/dma_req_sync_chan_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the channel synchronizer: one task per scenario.
module dma_req_sync_chan_tb_top;

    localparam int NUM_REQ  = 128;
    localparam int NUM_SYNC = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NUM_REQ-1:0]  req_bus = '0;
    logic [NUM_SYNC-1:0] sync_bus = '0;
    logic                dma_ack = 1'b0;
    logic                cfg_wr_en = 1'b0;
    logic [3:0]          cfg_wstrb = '0;
    logic [31:0]         cfg_wdata = '0;
    logic [31:0]         cfg_rdata;
    logic                dma_req_out;
    logic                evt_pulse;
    logic                ovr_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    dma_req_sync_chan #(
        .NUM_REQ  (NUM_REQ),
        .NUM_SYNC (NUM_SYNC)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_bus     (req_bus),
        .sync_bus    (sync_bus),
        .dma_ack     (dma_ack),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wstrb   (cfg_wstrb),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .dma_req_out (dma_req_out),
        .evt_pulse   (evt_pulse),
        .ovr_irq     (ovr_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] strb, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wstrb = strb;
        cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cfg_wstrb = '0;
    endtask

    task automatic set_sync(input int idx, input logic val);
        @(negedge clk);
        sync_bus[idx] = val;
        repeat (4) @(negedge clk);
    endtask

    task automatic ack_once();
        @(negedge clk);
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "rdata in reset", cfg_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rdata after reset", cfg_rdata, 32'h0);
        check("R1", "req out", {31'b0, dma_req_out}, 32'h0);
        check("R1", "evt/irq", {30'b0, evt_pulse, ovr_irq}, 32'h0);
    endtask

    task automatic t_lanes();
        wr(4'b1111, 32'hFFFF_FFFF);
        check("R7", "word write, unused bits zero", cfg_rdata, 32'h007F_FF7F);
        wr(4'b1111, 32'h0);
        check("R6", "count locked by enables", cfg_rdata, 32'h001F_0000);
        wr(4'b1111, 32'h0);
        check("R6", "count written when unlocked", cfg_rdata, 32'h0);
        wr(4'b0001, 32'hFFFF_FFFF);
        check("R7", "byte lane 0 only", cfg_rdata, 32'h0000_007F);
        wr(4'b0110, 32'hFFFF_FFFF);
        check("R7", "misaligned 0110 ignored", cfg_rdata, 32'h0000_007F);
        wr(4'b1100, 32'h0003_0000);
        check("R7", "upper halfword", cfg_rdata, 32'h0003_007F);
        wr(4'b1010, 32'hFFFF_FFFF);
        check("R7", "pattern 1010 ignored", cfg_rdata, 32'h0003_007F);
        wr(4'b1111, 32'h0);
    endtask

    task automatic t_pass();
        wr(4'b0001, 32'h0000_007F);
        req_bus = '0;
        req_bus[127] = 1'b1;
        #1 check("R2", "line 127 high", {31'b0, dma_req_out}, 32'h1);
        req_bus = ~req_bus;
        #1 check("R2", "line 127 low, others high", {31'b0, dma_req_out}, 32'h0);
        wr(4'b0001, 32'h0000_0005);
        #1 check("R2", "line 5", {31'b0, dma_req_out}, 32'h1);
        req_bus = '0;
    endtask

    task automatic t_window();
        req_bus[3] = 1'b1;
        wr(4'b1111, 32'h0002_BF03);
        check("R4", "gate closed before edge", {31'b0, dma_req_out}, 32'h0);
        set_sync(31, 1'b1);
        for (int k = 0; k < 3; k++) begin
            check("R4", "window open", {31'b0, dma_req_out}, 32'h1);
            ack_once();
        end
        check("R4", "closed after 3", {31'b0, dma_req_out}, 32'h0);
        check("R8", "no overrun", {31'b0, cfg_rdata[31]}, 32'h0);
    endtask

    task automatic t_polarity();
        wr(4'b0010, 32'h0000_DF00);
        set_sync(31, 1'b0);
        check("R3", "falling opens under 10", {31'b0, dma_req_out}, 32'h1);
        for (int k = 0; k < 3; k++) ack_once();
        check("R3", "window drained", {31'b0, dma_req_out}, 32'h0);
        set_sync(31, 1'b1);
        check("R3", "rising ignored under 10", {31'b0, dma_req_out}, 32'h0);
        wr(4'b0010, 32'h0000_9F00);
        set_sync(31, 1'b0);
        check("R3", "falling ignored under 00", {31'b0, dma_req_out}, 32'h0);
        set_sync(31, 1'b1);
        check("R3", "rising ignored under 00", {31'b0, dma_req_out}, 32'h0);
        wr(4'b0010, 32'h0000_FF00);
        set_sync(31, 1'b0);
        check("R3", "falling opens under 11", {31'b0, dma_req_out}, 32'h1);
        for (int k = 0; k < 3; k++) ack_once();
        set_sync(31, 1'b1);
        check("R3", "rising opens under 11", {31'b0, dma_req_out}, 32'h1);
    endtask

    task automatic t_overrun();
        set_sync(31, 1'b0);
        check("R8", "flag set on edge in open window", {31'b0, cfg_rdata[31]}, 32'h1);
        check("R9", "irq masked", {31'b0, ovr_irq}, 32'h0);
        wr(4'b0100, 32'h0040_0000);
        check("R6", "count kept while gating on", {27'b0, cfg_rdata[20:16]}, 32'h2);
        check("R9", "irq with enable", {31'b0, ovr_irq}, 32'h1);
        repeat (3) @(negedge clk);
        check("R8", "flag sticky", {31'b0, cfg_rdata[31]}, 32'h1);
        wr(4'b1000, 32'h8000_0000);
        check("R8", "flag cleared", {31'b0, cfg_rdata[31]}, 32'h0);
        check("R9", "irq cleared", {31'b0, ovr_irq}, 32'h0);
        for (int k = 0; k < 3; k++) ack_once();
        check("R8", "no reload by late edge", {31'b0, dma_req_out}, 32'h0);
        set_sync(0, 1'b1);
        check("R3", "unselected line ignored", {31'b0, dma_req_out}, 32'h0);
        set_sync(0, 1'b0);
        check("R3", "unselected fall ignored", {31'b0, dma_req_out}, 32'h0);
    endtask

    task automatic t_event();
        wr(4'b1111, 32'h0);
        wr(4'b1111, 32'h0021_0003);
        check("R6", "count written with enable", {27'b0, cfg_rdata[20:16]}, 32'h1);
        ack_once();
        check("R5", "no pulse after first", {31'b0, evt_pulse}, 32'h0);
        ack_once();
        check("R5", "pulse after second", {31'b0, evt_pulse}, 32'h1);
        @(negedge clk);
        check("R5", "pulse one cycle", {31'b0, evt_pulse}, 32'h0);
        wr(4'b0100, 32'h0027_0000);
        check("R6", "count locked by event enable", {27'b0, cfg_rdata[20:16]}, 32'h1);
    endtask

    task automatic t_max();
        int early_low = 0;
        wr(4'b1111, 32'h0);
        wr(4'b1111, 32'h003F_A07F);
        req_bus = '0;
        req_bus[127] = 1'b1;
        set_sync(0, 1'b1);
        for (int k = 0; k < 32; k++) begin
            if (!dma_req_out) early_low++;
            ack_once();
        end
        check("R4", "32 requests forwarded", early_low, 32'h0);
        check("R5", "pulse after 32nd", {31'b0, evt_pulse}, 32'h1);
        check("R4", "closed after 32", {31'b0, dma_req_out}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_lanes();
        t_pass();
        t_window();
        t_polarity();
        t_overrun();
        t_event();
        t_max();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule